// File: doc/BRIEF.md
# Scan test clock sequencer

The sequencer drives one test clock for each clock domain of a design under scan test. It runs from a fast reference clock. It turns each shift or capture step into a train of single-cycle pulses, one pulse per domain and never two in the same cycle. Between two pulses it holds every domain clock low for a set number of reference cycles.

During shift, the order is fixed. The domain whose flops sit nearest the scan output fires first, and the domain nearest the scan input fires last. This stops data from racing through a flop before that flop has passed on its old value. During capture, the order comes from a programmable list of domain indices. Pattern generation knows that list in advance, so it can predict that a domain captured later sees the values already updated by domains captured earlier.

When test mode is off, each domain output carries its functional clock unchanged. A gated functional clock is passed through the same way. When test mode is on, the sequencer pulse replaces that clock.

Top module: `scan_clk_seq`

## Requirements
- R1: While test_mode_i is low, every dom_clk_o bit equals the matching func_clk_i bit, and requests start nothing.
- R2: A shift_req_i seen while test_mode_i and scan_en_i are high starts a shift train. Domains fire from index NUM_DOM-1 down to index 0, each with one pulse that is high for exactly one reference cycle.
- R3: Consecutive pulses are separated by G low reference cycles, where G = gap_i, or G = 1 when gap_i is 0. gap_i is sampled when the train starts, and later changes do not affect that train.
- R4: cap_req_i starts a capture train only while scan_en_i is low. shift_req_i starts a shift train only while scan_en_i is high. A request under the wrong scan_en_i level produces no pulse and leaves busy_o low.
- R5: A capture train fires one domain per slot, starting at slot 0. Slot k fires the domain whose index is held in order bits [k*IDX_W +: IDX_W]. After reset the order is the identity, so slot k fires domain k.
- R6: At most one domain clock pulses in any cycle in test mode. A flop in a domain captured later therefore sees data already updated by a domain captured earlier.
- R7: busy_o is high from the cycle of the first pulse through the cycle of the last pulse. done_o is high for exactly the one cycle that follows the last pulse.
- R8: order_wr_i loads order_i only while the sequencer is idle. A write while busy is dropped.
- R9: If test_mode_i falls during a train, the train is abandoned. The sequencer returns to idle with no further pulse and without raising done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| test_mode_i | input | 1 | Selects test clocks over functional clocks |
| scan_en_i | input | 1 | High for shift phase, low for capture phase |
| shift_req_i | input | 1 | Request one shift cycle |
| cap_req_i | input | 1 | Request one capture cycle |
| gap_i | input | GAP_W | Low cycles between pulses (0 treated as 1) |
| order_wr_i | input | 1 | Load the capture order |
| order_i | input | NUM_DOM*IDX_W | Capture order, slot k in bits [k*IDX_W +: IDX_W] |
| func_clk_i | input | NUM_DOM | Functional (possibly gated) clock per domain |
| dom_clk_o | output | NUM_DOM | Clock delivered to each domain |
| busy_o | output | 1 | A pulse train is in progress |
| done_o | output | 1 | One-cycle flag after the last pulse |

## Verification
The bench builds the block with NUM_DOM = 4 and GAP_W = 3. With these values the whole gap range 0 to 7 can be driven, including the zero-gap floor and a gap change in the middle of a train. A non-identity capture permutation is compared against the identity reset order, and a write dropped while busy can be seen in the following train. Two bench flops, clocked by domains 2 and 0, show that data crosses between domains in the sequenced order.

// File: rtl/scs_pkg.sv
package scs_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_PULSE = 2'd1,
    SQ_GAP   = 2'd2
  } sq_state_e;
endpackage

// File: rtl/scs_order_reg.sv
module scs_order_reg #(
  parameter int NUM_DOM = 4,
  parameter int IDX_W   = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic                     busy_i,
  input  logic [NUM_DOM*IDX_W-1:0] order_i,
  output logic [NUM_DOM*IDX_W-1:0] order_o
);
  logic [NUM_DOM*IDX_W-1:0] ident;
  logic [NUM_DOM*IDX_W-1:0] order_q;

  for (genvar k = 0; k < NUM_DOM; k++) begin : g_ident
    assign ident[k*IDX_W +: IDX_W] = IDX_W'(k);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                order_q <= ident;
    else if (wr_i && !busy_i)   order_q <= order_i;
  end

  assign order_o = order_q;

  // R8: list frozen while a train runs
  p_order_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(order_q));
endmodule

// File: rtl/scs_pulse_seq.sv
module scs_pulse_seq
  import scs_pkg::*;
#(
  parameter int NUM_DOM = 4,
  parameter int IDX_W   = 2,
  parameter int GAP_W   = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     test_mode_i,
  input  logic                     scan_en_i,
  input  logic                     shift_req_i,
  input  logic                     cap_req_i,
  input  logic [GAP_W-1:0]         gap_i,
  input  logic [NUM_DOM*IDX_W-1:0] order_i,
  output logic [NUM_DOM-1:0]       pulse_o,
  output logic                     busy_o,
  output logic                     done_o
);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(NUM_DOM - 1);

  sq_state_e          state_q;
  logic [IDX_W-1:0]   slot_q;
  logic               cap_q;
  logic [GAP_W-1:0]   gap_q;
  logic [GAP_W-1:0]   gcnt_q;
  logic [NUM_DOM-1:0] pulse_q;
  logic               done_q;

  logic             start_shift, start_cap;
  logic [GAP_W-1:0] gap_eff;
  logic [IDX_W-1:0] slot_nxt;

  assign start_shift = test_mode_i &  scan_en_i & shift_req_i;
  assign start_cap   = test_mode_i & ~scan_en_i & cap_req_i;
  assign gap_eff     = (gap_i == '0) ? GAP_W'(1) : gap_i;
  assign slot_nxt    = slot_q + 1'b1;

  // shift: scan_out side (highest index) first; capture: programmed list
  function automatic logic [NUM_DOM-1:0] slot_hot(
    input logic [IDX_W-1:0]         slot,
    input logic                     cap,
    input logic [NUM_DOM*IDX_W-1:0] ord
  );
    logic [IDX_W-1:0] d;
    d = cap ? ord[slot*IDX_W +: IDX_W] : LAST_SLOT - slot;
    slot_hot = '0;
    slot_hot[d] = 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      slot_q  <= '0;
      cap_q   <= 1'b0;
      gap_q   <= GAP_W'(1);
      gcnt_q  <= '0;
      pulse_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!test_mode_i) begin
        state_q <= SQ_IDLE;
        pulse_q <= '0;
      end else begin
        unique case (state_q)
          SQ_IDLE: begin
            if (start_shift || start_cap) begin
              state_q <= SQ_PULSE;
              slot_q  <= '0;
              cap_q   <= start_cap;
              gap_q   <= gap_eff;
              pulse_q <= slot_hot('0, start_cap, order_i);
            end
          end
          SQ_PULSE: begin
            pulse_q <= '0;
            if (slot_q == LAST_SLOT) begin
              state_q <= SQ_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= SQ_GAP;
              gcnt_q  <= gap_q - 1'b1;
            end
          end
          SQ_GAP: begin
            if (gcnt_q == '0) begin
              state_q <= SQ_PULSE;
              slot_q  <= slot_nxt;
              pulse_q <= slot_hot(slot_nxt, cap_q, order_i);
            end else begin
              gcnt_q <= gcnt_q - 1'b1;
            end
          end
          default: state_q <= SQ_IDLE;
        endcase
      end
    end
  end

  assign pulse_o = pulse_q;
  assign busy_o  = (state_q != SQ_IDLE);
  assign done_o  = done_q;

  p_one_domain_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pulse_q));
  p_pulse_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_q != '0) |=> (pulse_q == '0));
  p_done_after_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!busy_o && $past(busy_o)));
  p_start_in_test_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(test_mode_i));
endmodule

// File: rtl/scs_clk_mux.sv
module scs_clk_mux #(
  parameter int NUM_DOM = 4
) (
  input  logic               test_mode_i,
  input  logic [NUM_DOM-1:0] pulse_i,
  input  logic [NUM_DOM-1:0] func_clk_i,
  output logic [NUM_DOM-1:0] dom_clk_o
);
  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    assign dom_clk_o[d] = test_mode_i ? pulse_i[d] : func_clk_i[d];
  end
endmodule

// File: rtl/scan_clk_seq.sv
module scan_clk_seq #(
  parameter int NUM_DOM = 4,
  parameter int GAP_W   = 4,
  localparam int IDX_W  = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     test_mode_i,
  input  logic                     scan_en_i,
  input  logic                     shift_req_i,
  input  logic                     cap_req_i,
  input  logic [GAP_W-1:0]         gap_i,
  input  logic                     order_wr_i,
  input  logic [NUM_DOM*IDX_W-1:0] order_i,
  input  logic [NUM_DOM-1:0]       func_clk_i,
  output logic [NUM_DOM-1:0]       dom_clk_o,
  output logic                     busy_o,
  output logic                     done_o
);
  logic [NUM_DOM*IDX_W-1:0] order_q;
  logic [NUM_DOM-1:0]       pulse;
  logic                     busy;

  scs_order_reg #(.NUM_DOM(NUM_DOM), .IDX_W(IDX_W)) u_order (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (order_wr_i),
    .busy_i  (busy),
    .order_i (order_i),
    .order_o (order_q)
  );

  scs_pulse_seq #(.NUM_DOM(NUM_DOM), .IDX_W(IDX_W), .GAP_W(GAP_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .test_mode_i (test_mode_i),
    .scan_en_i   (scan_en_i),
    .shift_req_i (shift_req_i),
    .cap_req_i   (cap_req_i),
    .gap_i       (gap_i),
    .order_i     (order_q),
    .pulse_o     (pulse),
    .busy_o      (busy),
    .done_o      (done_o)
  );

  scs_clk_mux #(.NUM_DOM(NUM_DOM)) u_mux (
    .test_mode_i (test_mode_i),
    .pulse_i     (pulse),
    .func_clk_i  (func_clk_i),
    .dom_clk_o   (dom_clk_o)
  );

  assign busy_o = busy;
endmodule

// File: tb/sim_scan_clk_seq.sv
module sim_scan_clk_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NDOM  = 4;
  localparam int GW    = 3;
  localparam int IW    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_mode = 1'b0, scan_en = 1'b0, shift_req = 1'b0, cap_req = 1'b0;
  logic [GW-1:0] gap = '0;
  logic order_wr = 1'b0;
  logic [NDOM*IW-1:0] order_in = '0;
  logic [NDOM-1:0] func_clk = '0;
  logic [NDOM-1:0] dom_clk;
  logic busy, done;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_clk_seq #(.NUM_DOM(NDOM), .GAP_W(GW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .test_mode_i(test_mode), .scan_en_i(scan_en),
    .shift_req_i(shift_req), .cap_req_i(cap_req), .gap_i(gap),
    .order_wr_i(order_wr), .order_i(order_in), .func_clk_i(func_clk),
    .dom_clk_o(dom_clk), .busy_o(busy), .done_o(done)
  );

  // R6 cross-domain flops: domain 2 feeds domain 0
  logic data_x = 1'b0, f_src = 1'b0, f_dst = 1'b0;
  always @(posedge dom_clk[2]) f_src <= data_x;
  always @(posedge dom_clk[0]) f_dst <= f_src;

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic idle_check(input string rq, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(rq, "busy", 32'(busy), 0);
      chk(rq, "dom_clk", 32'(dom_clk), 32'(test_mode ? '0 : func_clk));
      chk(rq, "done", 32'(done), 0);
    end
  endtask

  // one train; ord holds expected domain per slot, slot k at [2k+:2]
  task automatic run_seq(input string rq, input logic [7:0] ord, input int gp, input bit cap, input bit wr_mid);
    int g;
    int last;
    g = (gp == 0) ? 1 : gp;
    last = (NDOM - 1) * (g + 1);
    @(negedge clk);
    gap = GW'(gp);
    scan_en = !cap;
    if (cap) cap_req = 1'b1; else shift_req = 1'b1;
    for (int c = 0; c <= last + 1; c++) begin
      logic [NDOM-1:0] ep;
      @(negedge clk);
      ep = '0;
      if ((c % (g + 1)) == 0 && c <= last) ep[ord[(c/(g+1))*2 +: 2]] = 1'b1;
      chk(rq, $sformatf("dom_clk c=%0d", c), 32'(dom_clk), 32'(ep));
      chk("R7", $sformatf("busy c=%0d", c), 32'(busy), 32'(c <= last));
      chk("R7", $sformatf("done c=%0d", c), 32'(done), 32'(c == last + 1));
      if (c == 0) begin
        cap_req = 1'b0; shift_req = 1'b0;
        gap = 3'd7;  // R3: must not alter running train
      end
      if (wr_mid && c == 1) begin order_wr = 1'b1; order_in = 8'b11100100; end
      if (wr_mid && c == 2) order_wr = 1'b0;
    end
  endtask

  task automatic t_reset;
    chk("R7", "reset busy", 32'(busy), 0);
    chk("R7", "reset done", 32'(done), 0);
    chk("R1", "reset dom_clk", 32'(dom_clk), 0);
  endtask

  task automatic t_func;
    @(negedge clk); test_mode = 1'b0; func_clk = 4'b1010; scan_en = 1'b1; shift_req = 1'b1;
    @(negedge clk); chk("R1", "pass 1010", 32'(dom_clk), 32'hA);
    func_clk = 4'b0101; cap_req = 1'b1; scan_en = 1'b0;
    @(negedge clk); chk("R1", "pass 0101", 32'(dom_clk), 32'h5);
    chk("R1", "no start", 32'(busy), 0);
    shift_req = 1'b0; cap_req = 1'b0; func_clk = '0;
    @(negedge clk); test_mode = 1'b1;
  endtask

  task automatic t_ignore;
    @(negedge clk); scan_en = 1'b1; cap_req = 1'b1;
    @(negedge clk); cap_req = 1'b0;
    idle_check("R4", 3);
    scan_en = 1'b0; shift_req = 1'b1;
    @(negedge clk); shift_req = 1'b0;
    idle_check("R4", 3);
  endtask

  task automatic t_abort;
    @(negedge clk); gap = 3'd2; scan_en = 1'b1; shift_req = 1'b1;
    @(negedge clk); shift_req = 1'b0;
    chk("R9", "first pulse", 32'(dom_clk), 32'h8);
    @(negedge clk); test_mode = 1'b0;
    idle_check("R9", 3);
    test_mode = 1'b1;
    idle_check("R9", 8);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_func();
    run_seq("R2", 8'b00_01_10_11, 1, 1'b0, 1'b0);
    run_seq("R3", 8'b00_01_10_11, 0, 1'b0, 1'b0);
    run_seq("R3", 8'b00_01_10_11, 3, 1'b0, 1'b0);
    run_seq("R5", 8'b11_10_01_00, 1, 1'b1, 1'b0);
    t_ignore();
    @(negedge clk); order_wr = 1'b1; order_in = 8'b01_11_00_10;
    @(negedge clk); order_wr = 1'b0;
    data_x = ~f_dst;
    run_seq("R5", 8'b01_11_00_10, 2, 1'b1, 1'b1);
    chk("R6", "later domain sees update", 32'(f_dst), 32'(data_x));
    run_seq("R8", 8'b01_11_00_10, 1, 1'b1, 1'b0);
    t_abort();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule